// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction fetch stage. Each cycle it compares the current fetch address with a small fully associative set of remembered branch addresses. It reports three things in that same cycle: whether the address is a known branch, whether that branch is expected to be taken, and the destination recorded for it. When the entry predicts taken, the block raises a redirect flag and offers the recorded destination as the next fetch address, so a correctly predicted taken branch costs no stall cycle. In every other case the next fetch address is the sequential one.

Branches are resolved later in the pipeline. The resolving stage then sends back the branch address, the real direction and the real destination. If the branch already has an entry, that entry is rewritten in place. If it has no entry, a new one is made only when the branch was taken. A busy flag marks the cycle in which such a new entry is written, which is the extra penalty cycle paid by a taken branch that was not yet known. When every entry is in use, the victim is chosen by a rotating pointer.

Top module: `fetch_btb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup hits exactly when a valid entry holds a tag equal to `lk_pc`. On a hit, `lk_target` is that entry's stored destination.
- R3: `pred_taken` is the stored direction bit of the hit entry (1 taken, 0 not taken) and is 0 on a miss. `redirect` is high only for a hit that predicts taken. `next_pc` is `lk_target` when `redirect` is high and `lk_pc + STEP` otherwise (STEP = 4).
- R4: An update for an address with no entry that resolves not taken creates no entry.
- R5: An update for an address with no entry that resolves taken creates an entry predicting taken, holding the reported destination.
- R6: An update for an address that already has an entry rewrites that entry and never duplicates it. A taken outcome sets the direction bit and stores the new destination. A not-taken outcome clears the direction bit and leaves the stored destination as it was.
- R7: A new entry goes into the lowest-numbered free slot. When no slot is free, the victim is the slot named by a rotating pointer, which starts at slot 0 after reset and moves forward by one, wrapping, after each replacement.
- R8: The lookup result in a cycle reflects the contents before that cycle's update; the update is visible from the next cycle on.
- R9: `wr_busy` is high in exactly the cycles in which a valid update creates a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | AW | Fetch address being looked up |
| hit | output | 1 | Address matches a valid entry |
| pred_taken | output | 1 | Matching entry predicts taken |
| lk_target | output | AW | Stored destination of the matching entry |
| redirect | output | 1 | Fetch should jump to the stored destination |
| next_pc | output | AW | Address to fetch next |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 taken |
| upd_target | input | AW | Resolved destination |
| wr_busy | output | 1 | A new entry is being written this cycle |

## Verification
The hardest state to reach is a full buffer in which replacement has wrapped the rotating pointer, because that needs more distinct taken branches than there are slots. A directed sequence fills every slot and then forces two evictions, checking that the oldest addresses miss. The random phase then draws update addresses from a pool half again as large as the buffer, so that refreshes, not-taken clears and repeated evictions mix with lookups that match the address being updated in the same cycle.

// File: rtl/fetch_btb.sv
module fetch_btb #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int STEP    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_pc,
  output logic          hit,
  output logic          pred_taken,
  output logic [AW-1:0] lk_target,
  output logic          redirect,
  output logic [AW-1:0] next_pc,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target,
  output logic          wr_busy
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, tkn, lk_m, up_m;
  logic [AW-1:0]      tag [ENTRIES];
  logic [AW-1:0]      dst [ENTRIES];
  logic [IW-1:0]      rr, lk_idx, up_idx, free_idx, wr_idx;
  logic               up_hit, any_free;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_m[i] = vld[i] && (tag[i] == lk_pc);
    assign up_m[i] = vld[i] && (tag[i] == upd_pc);
  end

  always_comb begin
    lk_idx = '0;
    up_idx = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_idx = IW'(i);
      if (up_m[i]) up_idx = IW'(i);
      if (!vld[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign hit        = |lk_m;
  assign pred_taken = hit && tkn[lk_idx];
  assign lk_target  = dst[lk_idx];
  assign redirect   = pred_taken;
  assign next_pc    = redirect ? lk_target : lk_pc + AW'(STEP);

  assign up_hit  = |up_m;
  assign wr_busy = upd_valid && upd_taken && !up_hit;
  assign wr_idx  = up_hit ? up_idx : (any_free ? free_idx : rr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      tkn <= '0;
      rr  <= '0;
    end else if (upd_valid) begin
      if (up_hit) begin
        tkn[wr_idx] <= upd_taken;
      end else if (upd_taken) begin
        vld[wr_idx] <= 1'b1;
        tkn[wr_idx] <= 1'b1;
        if (!any_free) rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && upd_valid && upd_taken) begin
      tag[wr_idx] <= upd_pc;
      dst[wr_idx] <= upd_target;
    end
  end
endmodule

// File: rtl/fetch_btb_chk.sv
module fetch_btb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] lk_pc,
  input logic          hit,
  input logic          pred_taken,
  input logic [AW-1:0] lk_target,
  input logic          redirect,
  input logic          upd_valid,
  input logic [AW-1:0] upd_pc,
  input logic          upd_taken,
  input logic [AW-1:0] upd_target,
  input logic          wr_busy
);
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hit); // R1

  AST_BUSY_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (upd_valid && upd_taken)); // R9

  AST_BUSY_NOT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && lk_pc == upd_pc) |-> !hit); // R9

  AST_LEARN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (lk_pc != $past(upd_pc) || (hit && pred_taken && lk_target == $past(upd_target)))); // R5

  AST_CLEAR_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> (lk_pc != $past(upd_pc) || !pred_taken)); // R6

  AST_REDIRECT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (hit && pred_taken)); // R3
endmodule

bind fetch_btb fetch_btb_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .hit(hit), .pred_taken(pred_taken),
  .lk_target(lk_target), .redirect(redirect), .upd_valid(upd_valid),
  .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
  .wr_busy(wr_busy)
);

// File: tb/fetch_btb_test.sv
module fetch_btb_test;
  localparam int N = 16;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic hit, pred_taken, redirect, wr_busy;
  logic [AW-1:0] lk_target, next_pc;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  bit            m_vld [N];
  bit            m_tkn [N];
  logic [AW-1:0] m_tag [N];
  logic [AW-1:0] m_dst [N];
  int            m_rr;

  fetch_btb #(.ENTRIES(N), .AW(AW), .STEP(4)) uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .hit(hit), .pred_taken(pred_taken),
    .lk_target(lk_target), .redirect(redirect), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .wr_busy(wr_busy)
  );

  always #4 clk = ~clk;

  function automatic int find(logic [AW-1:0] pc);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tkn[i] = 0; end
    m_rr = 0;
  endtask

  task automatic step(logic [AW-1:0] lpc, bit uv, logic [AW-1:0] upc, bit ut,
                      logic [AW-1:0] utg, string tag);
    int li, ui, fi;
    logic [AW+AW+3:0] act, exp;
    bit e_hit, e_tk;
    logic [AW-1:0] e_tgt, e_nx;
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    li = find(lpc);
    ui = find(upc);
    e_hit = (li >= 0);
    e_tk  = e_hit && m_tkn[li];
    e_tgt = e_hit ? m_dst[li] : '0;
    e_nx  = e_tk ? e_tgt : lpc + 4;
    exp = {e_hit, e_tk, e_tk, e_tgt, e_nx, uv && ut && ui < 0};
    act = {hit, pred_taken, redirect, (hit ? lk_target : '0), next_pc, wr_busy};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc=%h: act hit/tk/rd/tgt/nx/busy=%h exp=%h", tag, lpc, act, exp);
    end
    @(posedge clk);
    if (uv) begin
      if (ui >= 0) begin
        m_tkn[ui] = ut;
        if (ut) m_dst[ui] = utg;
      end else if (ut) begin
        fi = first_free();
        if (fi < 0) begin fi = m_rr; m_rr = (m_rr + 1) % N; end
        m_vld[fi] = 1; m_tkn[fi] = 1; m_tag[fi] = upc; m_dst[fi] = utg;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_b7b));
    do_reset();
    // R1: empty after reset
    step(32'h100, 0, 0, 0, 0, "R1");
    step(32'h204, 0, 0, 0, 0, "R1");
    // R4: first-time not-taken is not learned
    step(32'h300, 1, 32'h300, 0, 32'h900, "R4");
    step(32'h300, 0, 0, 0, 0, "R4");
    // R5/R9/R8: first-time taken, same-cycle lookup sees old state
    step(32'h400, 1, 32'h400, 1, 32'h800, "R8 R9");
    step(32'h400, 0, 0, 0, 0, "R5 R2 R3");
    // R6: refresh in place, not-taken clears bit keeps target
    step(32'h400, 1, 32'h400, 0, 32'hdead, "R6");
    step(32'h400, 0, 0, 0, 0, "R6");
    step(32'h400, 1, 32'h400, 1, 32'hc00, "R6 R9");
    step(32'h400, 0, 0, 0, 0, "R6");
    // R7: fill and wrap replacement
    do_reset();
    for (int i = 0; i < N; i++) step(32'h1000 + 4*i, 1, 32'h1000 + 4*i, 1, 32'h5000 + i, "R7");
    step(32'h1000, 1, 32'h2000, 1, 32'h6000, "R7 R9");
    step(32'h1000, 0, 0, 0, 0, "R7");
    step(32'h2000, 1, 32'h2004, 1, 32'h6004, "R7");
    step(32'h1004, 0, 0, 0, 0, "R7");
    step(32'h1008, 0, 0, 0, 0, "R7 R2");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a, b;
      a = 32'h4000 + 4 * ($urandom % 24);
      b = ($urandom % 4 == 0) ? a : 32'h4000 + 4 * ($urandom % 24);
      step(a, $urandom % 3 != 0, b, $urandom % 3 != 0, 32'h8000 + ($urandom % 256) * 4,
           "R2 R3 R6 R7 R8");
    end
    done = 1;
  end

  initial begin
    while (!done && cycles < 200000) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule